// File: doc/BRIEF.md
# Configurable Dual Storage Element

This block is the storage stage of a programmable logic cell. It holds two storage elements, named A and B. Both elements use the same clock pin and the same clock-enable pin. Each element has its own static configuration bits. These bits set the clock polarity, choose between an edge-triggered flip-flop and a level-sensitive latch, choose the value that set/reset forces (1 or 0), and allow the enable to be treated as unconnected.

A shared set/reset input forces the configured value into both elements. A global active-low reset input does the same. Both act asynchronously and override any data capture. The configuration is expected to change only while the global reset is held low. The data width of each element is a parameter.

Top module: `dse_pair`

## Requirements
- R1: In flip-flop mode (`cfg_latch[i]`=0) with `cfg_inv[i]`=0 and the enable active, element i loads its data input on the rising edge of `clk`.
- R2: In flip-flop mode with `cfg_inv[i]`=1 and the enable active, element i loads its data input on the falling edge of `clk`, and ignores the rising edge.
- R3: The enable is active high and cannot be inverted. In flip-flop mode with the enable inactive, the element keeps its value across clock edges. In latch mode with the enable inactive, the element is opaque.
- R4: When `cfg_ceopen[i]`=1, element i behaves as if `ce` were always high.
- R5: In latch mode (`cfg_latch[i]`=1), element i follows its data input while the enable is active and the clock is at its active level: high when `cfg_inv[i]`=0, low when `cfg_inv[i]`=1. Otherwise it holds its value.
- R6: While `sr`=1, element i is forced at once to `cfg_setv[i]`, repeated across all bits. This holds whatever the clock and the enable do.
- R7: While `gsr_n`=0, each element is forced to its own `cfg_setv[i]` value. This is the state after power-up reset.
- R8: Both elements are driven from the same `clk` and `ce` pins. Bit i of each configuration port controls element i only (bit 0 is A, bit 1 is B). The behaviour of one element does not depend on the other element's configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared cell clock |
| ce | input | 1 | Shared clock enable, active high |
| sr | input | 1 | Shared asynchronous set/reset, active high |
| gsr_n | input | 1 | Global asynchronous set/reset, active low |
| d_a | input | WIDTH | Data input of element A |
| d_b | input | WIDTH | Data input of element B |
| cfg_inv | input | 2 | Per-element clock inversion |
| cfg_latch | input | 2 | Per-element latch mode select (1 = latch) |
| cfg_setv | input | 2 | Per-element forced value (0 = reset, 1 = set) |
| cfg_ceopen | input | 2 | Per-element "enable unconnected" flag |
| q_a | output | WIDTH | Stored value of element A |
| q_b | output | WIDTH | Stored value of element B |

## Verification
Assertions are checked on every active edge of each element's own clock. They cover four behaviours:
- Forcing: while set/reset is active, the element holds the configured value.
- Flip-flop capture: the element loads its data input when enabled.
- Flip-flop hold: the element keeps its value when disabled.
- Latch transparency: an open latch ends its phase equal to its input.

Some behaviours only the bench scenarios can show. These are:
- The global reset forcing while clocks toggle.
- An unconnected enable overriding a low `ce`.
- A latch tracking data in mid-phase.
- The isolation between the two elements.

The bench sweeps all 256 pairs of per-element configurations to cover them.

// File: rtl/dse_pkg.sv
`timescale 1ns/1ps
package dse_pkg;
  // Static per-element configuration
  typedef struct packed {
    logic ce_open;     // enable treated as tied high
    logic set_val;     // value forced by sr / gsr_n
    logic latch_mode;  // 1: level latch, 0: edge flip-flop
    logic clk_inv;     // 1: active on falling edge / low level
  } elem_cfg_t;

  localparam int unsigned NUM_ELEM = 2;
endpackage

// File: rtl/dse_ctl.sv
`timescale 1ns/1ps
// Per-element control: effective clock, enable and force
module dse_ctl (
  input  logic clk,
  input  logic ce,
  input  logic sr,
  input  logic gsr_n,
  input  logic clk_inv,
  input  logic ce_open,
  output logic eclk,
  output logic en,
  output logic frc
);
  always_comb begin
    eclk = clk ^ clk_inv;
    en   = ce | ce_open;
    frc  = sr | ~gsr_n;
  end
endmodule

// File: rtl/dse_store.sv
`timescale 1ns/1ps
// One storage element: flip-flop and latch paths, output chosen by mode
module dse_store #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             eclk,
  input  logic             en,
  input  logic             frc,
  input  logic             rst_n,
  input  logic             latch_mode,
  input  logic             set_val,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] force_val;
  logic [WIDTH-1:0] ff_q, ff_d;
  logic [WIDTH-1:0] lat_q;

  always_comb force_val = {WIDTH{set_val}};

  // next-state for the edge path
  always_comb ff_d = en ? d : ff_q;

  // edge path: asynchronous force has priority
  always_ff @(posedge eclk or posedge frc) begin
    if (frc) ff_q <= force_val;
    else     ff_q <= ff_d;
  end

  // level path: transparent at active clock level with enable
  always_latch begin
    if (frc)              lat_q <= force_val;
    else if (eclk && en)  lat_q <= d;
  end

  always_comb q = latch_mode ? lat_q : ff_q;

  // R6: output equals the forced value while forcing
  a_r6_force_holds: assert property (@(posedge eclk) disable iff (!rst_n)
    frc |-> q == force_val);

  // R1 / R2: enabled flip-flop loads the data seen at the active edge
  a_r1_flop_capture: assert property (@(posedge eclk) disable iff (!rst_n)
    (!latch_mode && en && !frc) |=> (frc || q == $past(d)));

  // R3: disabled flip-flop keeps its value
  a_r3_flop_hold: assert property (@(posedge eclk) disable iff (!rst_n)
    (!latch_mode && !en && !frc) |=> (frc || $stable(q)));

  // R5: an open latch ends its transparent phase equal to its input
  a_r5_latch_follow: assert property (@(negedge eclk) disable iff (!rst_n)
    (latch_mode && en && !frc) |-> q == d);
endmodule

// File: rtl/dse_pair.sv
`timescale 1ns/1ps
// Two configurable storage elements sharing clock and enable
module dse_pair #(
  parameter int unsigned WIDTH = 1
) (
  input  logic             clk,
  input  logic             ce,
  input  logic             sr,
  input  logic             gsr_n,
  input  logic [WIDTH-1:0] d_a,
  input  logic [WIDTH-1:0] d_b,
  input  logic [1:0]       cfg_inv,
  input  logic [1:0]       cfg_latch,
  input  logic [1:0]       cfg_setv,
  input  logic [1:0]       cfg_ceopen,
  output logic [WIDTH-1:0] q_a,
  output logic [WIDTH-1:0] q_b
);
  import dse_pkg::*;

  elem_cfg_t        cfg  [NUM_ELEM];
  logic [WIDTH-1:0] din  [NUM_ELEM];
  logic [WIDTH-1:0] dout [NUM_ELEM];

  always_comb begin
    din[0] = d_a;
    din[1] = d_b;
    q_a    = dout[0];
    q_b    = dout[1];
  end

  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_elem
    logic eclk, en, frc;

    always_comb begin
      cfg[i].ce_open    = cfg_ceopen[i];
      cfg[i].set_val    = cfg_setv[i];
      cfg[i].latch_mode = cfg_latch[i];
      cfg[i].clk_inv    = cfg_inv[i];
    end

    dse_ctl u_ctl (
      .clk     (clk),
      .ce      (ce),
      .sr      (sr),
      .gsr_n   (gsr_n),
      .clk_inv (cfg[i].clk_inv),
      .ce_open (cfg[i].ce_open),
      .eclk    (eclk),
      .en      (en),
      .frc     (frc)
    );

    dse_store #(.WIDTH(WIDTH)) u_store (
      .eclk       (eclk),
      .en         (en),
      .frc        (frc),
      .rst_n      (gsr_n),
      .latch_mode (cfg[i].latch_mode),
      .set_val    (cfg[i].set_val),
      .d          (din[i]),
      .q          (dout[i])
    );
  end
endmodule

// File: tb/dse_pair_test.sv
`timescale 1ns/1ps
module dse_pair_test;
  localparam int W = 4;
  localparam int HALF = 2; // 250 MHz: 4 ns period, one toggle per 2 ns step

  logic clk, ce, sr, gsr_n;
  logic [W-1:0] d_a, d_b, q_a, q_b;
  logic [1:0] cfg_inv, cfg_latch, cfg_setv, cfg_ceopen;

  int total = 0;
  int bad = 0;

  logic [W-1:0] mq [2];
  logic [3:0]   mc [2]; // {ceopen, setv, latch, inv}

  dse_pair #(.WIDTH(W)) uut (
    .clk(clk), .ce(ce), .sr(sr), .gsr_n(gsr_n), .d_a(d_a), .d_b(d_b),
    .cfg_inv(cfg_inv), .cfg_latch(cfg_latch), .cfg_setv(cfg_setv),
    .cfg_ceopen(cfg_ceopen), .q_a(q_a), .q_b(q_b)
  );

  // Reference model step for element e; edge=1 when clk just toggled
  task automatic model(input int e, input bit edge_ev);
    logic inv, lat, sv, op, ecl, en, frc;
    logic [W-1:0] d, q;
    string tag;
    inv = mc[e][0]; lat = mc[e][1]; sv = mc[e][2]; op = mc[e][3];
    ecl = clk ^ inv;
    en  = ce | op;
    frc = sr | ~gsr_n;
    d   = (e == 0) ? d_a : d_b;
    if (!gsr_n) begin
      mq[e] = {W{sv}}; tag = "R7";
    end else if (sr) begin
      mq[e] = {W{sv}}; tag = "R6";
    end else if (lat) begin
      if (ecl && en) mq[e] = d;
      tag = en ? "R5" : "R3";
    end else begin
      if (edge_ev && ecl && en) mq[e] = d;
      if (!en) tag = "R3";
      else if (op && !ce) tag = "R4";
      else tag = inv ? "R2" : "R1";
    end
    q = (e == 0) ? q_a : q_b;
    total++;
    if (q !== mq[e]) begin
      bad++;
      $display("FAIL %s (R8 elem %0d cfg=%b) got=%h expected=%h",
               tag, e, mc[e], q, mq[e]);
    end
    if (frc && q !== {W{sv}}) ; // covered above
  endtask

  task automatic apply(input logic ce_v, input logic sr_v, input logic g_v,
                       input logic [W-1:0] da, input logic [W-1:0] db);
    ce = ce_v; sr = sr_v; gsr_n = g_v; d_a = da; d_b = db;
    #1;
    for (int e = 0; e < 2; e++) model(e, 1'b0);
    #(HALF-1);
  endtask

  task automatic tick();
    clk = ~clk;
    #1;
    for (int e = 0; e < 2; e++) model(e, 1'b1);
    #(HALF-1);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clk = 0; ce = 0; sr = 0; gsr_n = 1; d_a = '0; d_b = '0;
    cfg_inv = 0; cfg_latch = 0; cfg_setv = 0; cfg_ceopen = 0;
    #1;
    for (int combo = 0; combo < 256; combo++) begin
      // reconfigure only under global reset (R7)
      gsr_n = 0;
      #1;
      mc[0] = combo[3:0];
      mc[1] = combo[7:4];
      cfg_inv    = {mc[1][0], mc[0][0]};
      cfg_latch  = {mc[1][1], mc[0][1]};
      cfg_setv   = {mc[1][2], mc[0][2]};
      cfg_ceopen = {mc[1][3], mc[0][3]};
      #1;
      tick(); // R7 with clock running
      tick();
      for (int j = 0; j < 8; j++) begin
        logic [W-1:0] da, db;
        logic cev, srv;
        da  = W'(combo * 7 + j * 3 + 1);
        db  = ~da ^ W'(j);
        cev = ((8'hB6 >> j) & 1) != 0;
        srv = (j == 5) || (j == 6); // R6 held across a full period
        apply(cev ^ combo[0], srv, 1'b1, da, db);
        // change data again mid-phase so open latches must track (R5)
        if (j == 2) apply(cev ^ combo[0], srv, 1'b1, ~da, da);
        tick();
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule